// File: doc/BRIEF.md
# 10BASE-T Receive Nibble Formatter

This block sits between a Manchester decoder and a 4-bit MII receive interface. It takes one recovered serial bit per strobe, together with a flag that says whether carrier is present. It looks for the preamble and the start-of-frame delimiter (SFD), shapes the carrier-sense (`crs`) and data-valid (`rx_dv`) outputs, and packs the serial stream into nibbles on `rxd`.

A configuration input chooses between two preamble modes. In strip mode the preamble is hidden and data-valid rises on the delimiter. In pass mode the preamble is forwarded and data-valid rises together with carrier-sense. A second configuration input chooses when `crs` falls: at the raw end of carrier, or in the same cycle as `rx_dv`. A frame may end a few bits past a byte boundary. A short remainder is padded with ones into one nibble. A longer remainder loses its incomplete second nibble.

The upstream decoder must deliver at most one bit strobe in any two consecutive cycles. The preamble detection length `PRE_BITS` must be a multiple of 4.

Top module: `mii_rx_nibbler`

## Requirements
- R1: After reset `rxd`, `rx_dv` and `crs` are 0, and `rxd` reads 0 in every cycle in which `rx_dv` is low.
- R2: `crs` rises after the clock edge that samples the `PRE_BITS`-th (default 4) consecutive alternating bit that starts with a 1 while `car_on` is high. A stream that never holds such a run never raises `crs`.
- R3: In strip mode (`cfg_pass_pre`=0), `rx_dv` stays low through the preamble. On the edge that samples the last SFD bit, `rx_dv` rises with `rxd`=0x5, and the next cycle shows `rxd`=0xD.
- R4: In pass mode (`cfg_pass_pre`=1), `crs` and `rx_dv` rise on the same edge with `rxd`=0x5. After that a nibble is shown every 4 bits, and the edge that samples the last SFD bit shows 0xD.
- R5: The SFD is the serial sequence 1,0,1,0,1,0,1,1, recognised at any bit position once `crs` is high.
- R6: The first serial bit of a nibble lands in `rxd[0]`. The low nibble of each byte precedes the high nibble. A nibble appears after the edge that samples its fourth bit.
- R7: The frame ends on the first edge that samples `car_on` low. If 0 or 4 to 7 bits follow the last whole byte, `rx_dv` falls after that edge.
- R8: If 1 to 3 bits follow the last whole byte, they are shown for one cycle after the end edge, in `rxd[0]` upward, with the remaining positions set to 1. `rx_dv` falls one edge later.
- R9: If 5 to 7 bits follow the last whole byte, their first 4 bits form a normal nibble and the rest are discarded.
- R10: With `cfg_crs_sync`=0, `crs` falls after the end edge. With `cfg_crs_sync`=1, `crs` falls on the same edge as `rx_dv`.
- R11: If `car_on` drops before the SFD, `crs` (and in pass mode `rx_dv`) fall after the edge that samples `car_on` low. In strip mode `rx_dv` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_dat` holds a recovered bit |
| bit_dat | input | 1 | Recovered serial bit |
| car_on | input | 1 | Carrier present from the line decoder |
| cfg_pass_pre | input | 1 | 1 = forward preamble, 0 = strip it |
| cfg_crs_sync | input | 1 | 1 = `crs` falls with `rx_dv` |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |

## Verification
The hardest case to reach from the ports is a frame whose end falls in each of the eight bit positions of a byte. This must happen under every combination of the two configuration inputs, because the padded nibble and the late `crs` edge appear only in a few of those combinations. The bench builds frames with 0 to 7 dribble bits, two preamble lengths and one or two body bytes, under all four modes. It computes the expected `rxd`, `rx_dv` and `crs` value for every cycle from the bit positions of each frame. A frame cut off inside the preamble and a non-alternating noise burst cover the cases where `crs` must stay low or fall early.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  localparam int NIB_W = 4;
  localparam int SFD_W = 8;

  // serial delimiter, oldest bit at the MSB
  localparam logic [SFD_W-1:0] SFD_SER = 8'b1010_1011;
  localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;
  localparam logic [NIB_W-1:0] NIB_SFD = 4'hD;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD2,
    ST_DATA,
    ST_TAIL
  } mrx_state_e;

  // keep the first 'fill' bits, force the rest to one
  function automatic logic [NIB_W-1:0] pad_ones(input logic [NIB_W-1:0] nib,
                                                input logic [1:0] fill);
    logic [NIB_W-1:0] r;
    for (int i = 0; i < NIB_W; i++) begin
      r[i] = (i < int'(fill)) ? nib[i] : 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/mrx_frame_hunt.sv
module mrx_frame_hunt
  import mrx_pkg::*;
#(
  parameter int PRE_BITS = 4,
  localparam int CNT_W = (PRE_BITS > 1) ? $clog2(PRE_BITS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_dat,
  input  logic car_on,
  input  logic hunt,
  input  logic sr_clr,
  output logic pre_ok,
  output logic sfd_hit
);

  logic [CNT_W-1:0] alt_q, alt_n;
  logic [SFD_W-2:0] sr_q, sr_n;
  logic             bit_in;
  logic             want;

  assign bit_in = bit_vld && car_on;
  // an even count expects a one, an odd count a zero
  assign want   = ~alt_q[0];

  always_comb begin
    alt_n  = alt_q;
    pre_ok = 1'b0;
    if (!hunt || !car_on) begin
      alt_n = '0;
    end else if (bit_vld) begin
      if (bit_dat == want) begin
        if (alt_q == CNT_W'(PRE_BITS - 1)) begin
          pre_ok = 1'b1;
          alt_n  = '0;
        end else begin
          alt_n = alt_q + 1'b1;
        end
      end else begin
        alt_n = bit_dat ? CNT_W'(1) : '0;
      end
    end
  end

  always_comb begin
    sr_n = sr_q;
    if (sr_clr) begin
      sr_n = '0;
    end else if (bit_in) begin
      sr_n = {sr_q[SFD_W-3:0], bit_dat};
    end
  end

  assign sfd_hit = bit_in && !hunt && ({sr_q, bit_dat} == SFD_SER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= '0;
      sr_q  <= '0;
    end else begin
      alt_q <= alt_n;
      sr_q  <= sr_n;
    end
  end

endmodule

// File: rtl/mrx_nib_pack.sv
module mrx_nib_pack
  import mrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             bit_dat,
  output logic             nib_done,
  output logic [NIB_W-1:0] nib_full,
  output logic [2:0]       byte_cnt,
  output logic [NIB_W-1:0] pad_val
);

  logic [2:0]       cnt_q, cnt_n;
  logic [NIB_W-1:0] nib_q, nib_n;

  always_comb begin
    nib_full              = nib_q;
    nib_full[cnt_q[1:0]]  = bit_dat;
  end

  assign nib_done = take && (cnt_q[1:0] == 2'd3);
  assign byte_cnt = cnt_q;
  assign pad_val  = pad_ones(nib_q, cnt_q[1:0]);

  always_comb begin
    cnt_n = cnt_q;
    nib_n = nib_q;
    if (clr) begin
      cnt_n = '0;
    end else if (take) begin
      cnt_n = cnt_q + 3'd1;
      nib_n = nib_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nib_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      nib_q <= nib_n;
    end
  end

endmodule

// File: rtl/mrx_mii_ctrl.sv
module mrx_mii_ctrl
  import mrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             car_on,
  input  logic             cfg_pass_pre,
  input  logic             cfg_crs_sync,
  input  logic             pre_ok,
  input  logic             sfd_hit,
  input  logic             nib_done,
  input  logic [NIB_W-1:0] nib_full,
  input  logic [2:0]       byte_cnt,
  input  logic [NIB_W-1:0] pad_val,
  output logic             hunt,
  output logic             sr_clr,
  output logic             asm_clr,
  output logic             take,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             crs
);

  mrx_state_e       st_q, st_n;
  logic [NIB_W-1:0] rxd_q, rxd_n;
  logic             dv_q, dv_n;
  logic             crs_q, crs_n;
  logic             need_pad;

  assign hunt     = (st_q == ST_IDLE);
  assign sr_clr   = hunt && !car_on;
  assign asm_clr  = hunt || ((st_q == ST_PRE) && sfd_hit);
  assign take     = !hunt && car_on && bit_vld;
  // 1..3 bits beyond the last whole byte
  assign need_pad = !byte_cnt[2] && (byte_cnt[1:0] != 2'd0);

  always_comb begin
    st_n  = st_q;
    rxd_n = rxd_q;
    dv_n  = dv_q;
    crs_n = crs_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pre_ok) begin
          st_n  = ST_PRE;
          crs_n = 1'b1;
          if (cfg_pass_pre) begin
            dv_n  = 1'b1;
            rxd_n = NIB_PRE;
          end
        end
      end
      ST_PRE: begin
        if (!car_on) begin
          st_n  = ST_IDLE;
          crs_n = 1'b0;
          dv_n  = 1'b0;
          rxd_n = '0;
        end else if (sfd_hit) begin
          dv_n = 1'b1;
          if (cfg_pass_pre) begin
            rxd_n = NIB_SFD;
            st_n  = ST_DATA;
          end else begin
            rxd_n = NIB_PRE;
            st_n  = ST_SFD2;
          end
        end else if (nib_done && cfg_pass_pre) begin
          rxd_n = nib_full;
        end
      end
      ST_SFD2: begin
        rxd_n = NIB_SFD;
        st_n  = ST_DATA;
      end
      ST_DATA: begin
        if (!car_on) begin
          if (need_pad) begin
            st_n  = ST_TAIL;
            rxd_n = pad_val;
            if (!cfg_crs_sync) begin
              crs_n = 1'b0;
            end
          end else begin
            st_n  = ST_IDLE;
            crs_n = 1'b0;
            dv_n  = 1'b0;
            rxd_n = '0;
          end
        end else if (nib_done) begin
          rxd_n = nib_full;
        end
      end
      ST_TAIL: begin
        st_n  = ST_IDLE;
        crs_n = 1'b0;
        dv_n  = 1'b0;
        rxd_n = '0;
      end
      default: begin
        st_n  = ST_IDLE;
        crs_n = 1'b0;
        dv_n  = 1'b0;
        rxd_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rxd_q <= '0;
      dv_q  <= 1'b0;
      crs_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      rxd_q <= rxd_n;
      dv_q  <= dv_n;
      crs_q <= crs_n;
    end
  end

  assign rxd   = rxd_q;
  assign rx_dv = dv_q;
  assign crs   = crs_q;

endmodule

// File: rtl/mii_rx_nibbler.sv
module mii_rx_nibbler
  import mrx_pkg::*;
#(
  parameter int PRE_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_dat,
  input  logic       car_on,
  input  logic       cfg_pass_pre,
  input  logic       cfg_crs_sync,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       crs
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             pre_ok, sfd_hit, hunt, sr_clr, asm_clr, take;
  logic             nib_done;
  logic [NIB_W-1:0] nib_full, pad_val;
  logic [2:0]       byte_cnt;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  mrx_frame_hunt #(.PRE_BITS(PRE_BITS)) u_hunt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_vld (bit_vld),
    .bit_dat (bit_dat),
    .car_on  (car_on),
    .hunt    (hunt),
    .sr_clr  (sr_clr),
    .pre_ok  (pre_ok),
    .sfd_hit (sfd_hit)
  );

  mrx_nib_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (asm_clr),
    .take     (take),
    .bit_dat  (bit_dat),
    .nib_done (nib_done),
    .nib_full (nib_full),
    .byte_cnt (byte_cnt),
    .pad_val  (pad_val)
  );

  mrx_mii_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bit_vld      (bit_vld),
    .car_on       (car_on),
    .cfg_pass_pre (cfg_pass_pre),
    .cfg_crs_sync (cfg_crs_sync),
    .pre_ok       (pre_ok),
    .sfd_hit      (sfd_hit),
    .nib_done     (nib_done),
    .nib_full     (nib_full),
    .byte_cnt     (byte_cnt),
    .pad_val      (pad_val),
    .hunt         (hunt),
    .sr_clr       (sr_clr),
    .asm_clr      (asm_clr),
    .take         (take),
    .rxd          (rxd),
    .rx_dv        (rx_dv),
    .crs          (crs)
  );

endmodule

// File: rtl/mrx_checks.sv
module mrx_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       car_on,
  input logic       cfg_pass_pre,
  input logic       cfg_crs_sync,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       crs
);

  a_r1_rxd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> (rxd == 4'h0));

  a_r3_dv_under_crs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> crs);

  a_r3_strip_crs_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pass_pre && $rose(crs)) |-> !rx_dv);

  a_r3_strip_first_nib: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pass_pre && $rose(rx_dv)) |-> (rxd == 4'h5));

  a_r4_pass_together: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pass_pre && $rose(crs)) |-> (rx_dv && rxd == 4'h5));

  a_r10_sync_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_crs_sync && $fell(rx_dv)) |-> !crs);

  a_r7_crs_after_car: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs) |-> (!$past(car_on) || !$past(car_on, 2)));

endmodule

bind mii_rx_nibbler mrx_checks u_mrx_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .car_on       (car_on),
  .cfg_pass_pre (cfg_pass_pre),
  .cfg_crs_sync (cfg_crs_sync),
  .rxd          (rxd),
  .rx_dv        (rx_dv),
  .crs          (crs)
);

// File: tb/test_mii_rx_nibbler.sv
module test_mii_rx_nibbler;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 3;   // cycles between bit strobes
  localparam int T0         = 2;   // first strobe slot in a frame
  localparam int MAXB       = 128;
  localparam int MAXT       = 512;

  logic       clk;
  logic       rst_n;
  logic       bit_vld, bit_dat, car_on, cfg_pass_pre, cfg_crs_sync;
  logic [3:0] rxd;
  logic       rx_dv, crs;

  int errs;
  int checks;
  bit done;

  bit         s_bits [MAXB];
  int         nbits;
  int         e_end;
  int         tlen;
  bit         ev_has [MAXT];
  bit         ev_dv  [MAXT];
  bit         ev_crs [MAXT];
  logic [3:0] ev_rxd [MAXT];
  bit         ex_dv  [MAXT];
  bit         ex_crs [MAXT];
  logic [3:0] ex_rxd [MAXT];

  mii_rx_nibbler i_mii_rx_nibbler (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_vld      (bit_vld),
    .bit_dat      (bit_dat),
    .car_on       (car_on),
    .cfg_pass_pre (cfg_pass_pre),
    .cfg_crs_sync (cfg_crs_sync),
    .rxd          (rxd),
    .rx_dv        (rx_dv),
    .crs          (crs)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eb(int k);
    return T0 + k * GAP;
  endfunction

  // kind 0: full frame, 1: carrier lost in preamble, 2: noise
  task automatic build_bits(int kind, int lp, int nbytes, int drib, int seed);
    nbits = 0;
    if (kind == 2) begin
      for (int i = 0; i < 10; i++) begin
        s_bits[nbits] = ((i / 2) % 2) == 0;   // 1,1,0,0,1,1,...
        nbits++;
      end
    end else begin
      for (int i = 0; i < lp; i++) begin
        s_bits[nbits] = (i % 2) == 0;
        nbits++;
      end
      if (kind == 0) begin
        for (int i = 0; i < 8; i++) begin
          s_bits[nbits] = (i % 2 == 0) || (i == 7);   // R5 delimiter
          nbits++;
        end
        for (int b = 0; b < nbytes; b++) begin
          int v;
          v = (seed * 29 + b * 71 + 5) & 8'hFF;
          for (int i = 0; i < 8; i++) begin
            s_bits[nbits] = v[i];
            nbits++;
          end
        end
        for (int i = 0; i < drib; i++) begin
          int v;
          v = (seed * 13 + 7) & 8'hFF;
          s_bits[nbits] = v[i];
          nbits++;
        end
      end
    end
    e_end = eb(nbits);
    tlen  = e_end + 4;
  endtask

  task automatic put(int t, bit dv, bit cr, logic [3:0] v);
    ev_has[t] = 1'b1;
    ev_dv[t]  = dv;
    ev_crs[t] = cr;
    ev_rxd[t] = v;
  endtask

  function automatic logic [3:0] nib_at(int last);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = s_bits[last - 3 + i];
    return v;
  endfunction

  task automatic build_expect(int kind, int lp, int drib, bit pass, bit sync);
    bit         cd, cc;
    logic [3:0] cr;
    for (int t = 0; t < MAXT; t++) ev_has[t] = 1'b0;
    if (kind != 2) begin
      put(eb(3), pass, 1'b1, pass ? 4'h5 : 4'h0);            // R2
      if (kind == 0) begin
        if (pass) begin
          for (int k = 7; k < lp + 7; k += 4) put(eb(k), 1'b1, 1'b1, 4'h5);
          put(eb(lp + 7), 1'b1, 1'b1, 4'hD);                  // R4
        end else begin
          put(eb(lp + 7), 1'b1, 1'b1, 4'h5);                  // R3
          put(eb(lp + 7) + 1, 1'b1, 1'b1, 4'hD);
        end
        for (int p = lp + 11; p < nbits; p += 4) begin        // R6, R9
          put(eb(p), 1'b1, 1'b1, nib_at(p));
        end
        if (drib >= 1 && drib <= 3) begin                     // R8
          logic [3:0] pv;
          pv = 4'hF;
          for (int i = 0; i < drib; i++) pv[i] = s_bits[nbits - drib + i];
          put(e_end, 1'b1, sync, pv);                         // R10
          put(e_end + 1, 1'b0, 1'b0, 4'h0);
        end else begin
          put(e_end, 1'b0, 1'b0, 4'h0);                       // R7
        end
      end else begin
        if (pass) begin
          for (int k = 7; k < nbits; k += 4) put(eb(k), 1'b1, 1'b1, 4'h5);
        end
        put(e_end, 1'b0, 1'b0, 4'h0);                         // R11
      end
    end
    cd = 1'b0;
    cc = 1'b0;
    cr = 4'h0;
    for (int t = 0; t < tlen; t++) begin
      if (ev_has[t]) begin
        cd = ev_dv[t];
        cc = ev_crs[t];
        cr = ev_rxd[t];
      end
      ex_dv[t]  = cd;
      ex_crs[t] = cc;
      ex_rxd[t] = cr;
    end
  endtask

  // called at a falling edge; inputs for edge t are set before it
  task automatic run_frame(bit pass, bit sync, string req);
    int         bad_rxd, bad_dv, bad_crs;
    logic [3:0] a_rxd, x_rxd;
    bit         a_dv, x_dv, a_crs, x_crs;
    bad_rxd = -1;
    bad_dv  = -1;
    bad_crs = -1;
    a_rxd = 0; x_rxd = 0; a_dv = 0; x_dv = 0; a_crs = 0; x_crs = 0;
    cfg_pass_pre = pass;
    cfg_crs_sync = sync;
    for (int t = 0; t < tlen; t++) begin
      car_on  = (t >= T0) && (t < e_end);
      bit_vld = 1'b0;
      bit_dat = 1'b0;
      if (t >= T0 && ((t - T0) % GAP) == 0 && ((t - T0) / GAP) < nbits) begin
        bit_vld = 1'b1;
        bit_dat = s_bits[(t - T0) / GAP];
      end
      @(posedge clk);
      @(negedge clk);
      if (bad_rxd < 0 && rxd !== ex_rxd[t]) begin
        bad_rxd = t; a_rxd = rxd; x_rxd = ex_rxd[t];
      end
      if (bad_dv < 0 && rx_dv !== ex_dv[t]) begin
        bad_dv = t; a_dv = rx_dv; x_dv = ex_dv[t];
      end
      if (bad_crs < 0 && crs !== ex_crs[t]) begin
        bad_crs = t; a_crs = crs; x_crs = ex_crs[t];
      end
    end
    chk(bad_rxd < 0, req, $sformatf("rxd at cycle %0d", bad_rxd), a_rxd, x_rxd);
    chk(bad_dv < 0, req, $sformatf("rx_dv at cycle %0d", bad_dv), a_dv, x_dv);
    chk(bad_crs < 0, req, $sformatf("crs at cycle %0d", bad_crs), a_crs, x_crs);
  endtask

  initial begin
    errs = 0;
    checks = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bit_vld = 1'b0;
    bit_dat = 1'b0;
    car_on = 1'b0;
    cfg_pass_pre = 1'b0;
    cfg_crs_sync = 1'b0;
    repeat (4) @(negedge clk);
    chk(rxd == 4'h0 && !rx_dv && !crs, "R1", "outputs in reset",
        {rxd, rx_dv, crs}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rxd == 4'h0 && !rx_dv && !crs, "R1", "outputs after reset",
        {rxd, rx_dv, crs}, 0);

    // non-alternating burst: R2 nothing may rise
    for (int pm = 0; pm < 2; pm++) begin
      build_bits(2, 0, 0, 0, 0);
      build_expect(2, 0, 0, pm[0], 1'b0);
      run_frame(pm[0], 1'b0, "R2 noise");
    end

    // carrier lost before the delimiter: R11
    for (int pm = 0; pm < 2; pm++) begin
      for (int sm = 0; sm < 2; sm++) begin
        build_bits(1, 8, 0, 0, 0);
        build_expect(1, 8, 0, pm[0], sm[0]);
        run_frame(pm[0], sm[0], pm[0] ? "R11 R4" : "R11 R3");
      end
    end

    // full sweep of modes, preamble lengths, sizes and dribble counts
    for (int pm = 0; pm < 2; pm++) begin
      for (int sm = 0; sm < 2; sm++) begin
        for (int li = 0; li < 2; li++) begin
          for (int nb = 1; nb <= 2; nb++) begin
            for (int d = 0; d < 8; d++) begin
              int    lp;
              string req;
              lp  = 4 + 8 * li;
              req = {pm[0] ? "R4" : "R3", " R5 R6 ",
                     (d == 0 || d == 4) ? "R7" : ((d < 4) ? "R8" : "R9"),
                     sm[0] ? " R10" : " R2"};
              build_bits(0, lp, nb, d, pm * 64 + sm * 32 + li * 16 + nb * 8 + d);
              build_expect(0, lp, d, pm[0], sm[0]);
              run_frame(pm[0], sm[0], req);
            end
          end
        end
      end
    end

    summary();
  end

endmodule